// File: doc/BRIEF.md
# Rolling Shutter Row Pointer Sequencer

This block produces the row timing for an image array read in rolling shutter fashion. Two row pointers run side by side: a readout pointer, which names the row being read, and a reset pointer, which names the row whose integration is being restarted. A frame-start pulse issues a readout sync. That sync loads the readout pointer from its configuration input and restarts two counters. Every row clock after that moves both pointers on by one row, wrapping at the end of the array, and advances both counters.

The integration counter is compared against the integration setting. When the two are equal, a reset sync is issued once and the reset pointer is loaded from its own configuration input. From then on the reset pointer trails the readout sequence by the programmed number of lines. The line counter is compared against the line-count setting, which holds the number of lines minus one. When the two are equal, a single last-line pulse is issued. The integration time in lines is the line-count setting minus the integration setting.

Top module: `rs_row_sequencer`

## Requirements
- R1: After reset, all three pulse outputs are 0 and both row pointers are 0. Row clocks that arrive before the first frame start move the pointers but produce no sync or last-line pulse.
- R2: When frame_start_i is sampled high, rd_sync_o is 1 for exactly the next clock cycle, and rd_row_o takes the value of rd_ptr_cfg_i in that same cycle.
- R3: When row_clk_i is sampled high, each pointer that its sync does not load in that cycle advances by one row.
- R4: A pointer at row NUM_ROWS-1 advances to row 0.
- R5: rst_sync_o pulses for one cycle once tint_cfg_i row clocks have been counted since the last frame start. In that cycle rst_row_o equals rst_ptr_cfg_i. With tint_cfg_i = 0, the pulse comes one cycle after rd_sync_o.
- R6: last_line_o pulses for one cycle once nlines_cfg_i row clocks have been counted since the last frame start. nlines_cfg_i holds the number of lines minus one.
- R7: If a pointer's sync loads it in the same cycle that a row clock is sampled, the pointer takes the loaded value and does not advance.
- R8: A new frame start clears both counters and rearms both pulses, including in the middle of a frame. Row clocks counted before it are discarded.
- R9: Within one frame, rst_sync_o and last_line_o each fire at most once. Further row clocks do not repeat them.
- R10: Both settings are 12 bits wide. The number of row clocks between rst_sync_o and last_line_o equals nlines_cfg_i minus tint_cfg_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start_i | input | 1 | Frame start pulse |
| row_clk_i | input | 1 | Row advance strobe, one cycle per row |
| rd_ptr_cfg_i | input | ROW_W | Readout pointer start row |
| rst_ptr_cfg_i | input | ROW_W | Reset pointer start row |
| nlines_cfg_i | input | 12 | Line count minus one |
| tint_cfg_i | input | 12 | Integration offset in lines |
| rd_sync_o | output | 1 | Readout sync pulse |
| rst_sync_o | output | 1 | Reset sync pulse |
| rd_row_o | output | ROW_W | Readout row pointer |
| rst_row_o | output | ROW_W | Reset row pointer |
| last_line_o | output | 1 | Last-line pulse |

## Verification
The assertions check on every cycle that a frame start is followed by a readout sync carrying the configured row. They also check that both pulses are one cycle wide, that pointers advance by one with wrap or stay stable, and that a reset sync carries the configured reset row. Only the bench scenarios can show that the reset sync and last-line pulse land after the correct number of row clocks, and that they fire once per frame. The same holds for the gap between them matching the line count minus the integration setting, for a mid-frame restart discarding earlier rows, and for a load taking priority over a coincident row clock.

// File: rtl/rs_seq_pkg.sv
// Package: shared widths and types for the rolling shutter row sequencer.
// Assumes: line-count and integration settings are 12 bits each.
package rs_seq_pkg;
    localparam int CFG_W = 12;
    typedef logic [CFG_W-1:0] cfg_t;
endpackage

// File: rtl/rs_row_ptr.sv
// Module: one row pointer that can be loaded or advanced, wrapping at the array end.
// Assumes: load_val_i < NUM_ROWS. A load wins over an advance in the same cycle.
module rs_row_ptr #(
    parameter int ROW_W    = 10,
    parameter int NUM_ROWS = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [ROW_W-1:0] load_val_i,
    input  logic             adv_i,
    output logic [ROW_W-1:0] row_o
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

    logic [ROW_W-1:0] row_q;
    logic [ROW_W-1:0] row_next;

    // Purpose: next row when advancing, with wrap to zero.
    always_comb begin
        row_next = (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
    end

    // Purpose: pointer register; a load takes priority and holds the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (load_i) begin
            row_q <= load_val_i;
        end else if (adv_i) begin
            row_q <= row_next;
        end
    end

    assign row_o = row_q;
endmodule

// File: rtl/rs_match_counter.sv
// Module: armed up-counter that raises fire_o once when its count equals the target.
// Assumes: start_i clears the count and rearms. After firing, it stays idle until the next start.
module rs_match_counter
    import rs_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic step_i,
    input  cfg_t target_i,
    output logic fire_o
);
    cfg_t cnt_q;
    logic armed_q;
    logic match;

    // Purpose: compare the count with the target while armed and not restarting.
    always_comb begin
        match = armed_q && (cnt_q == target_i) && !start_i;
    end

    // Purpose: count steps until a match, then disarm. A start clears and rearms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (start_i) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else if (match) begin
            armed_q <= 1'b0;
        end else if (armed_q && step_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign fire_o = match;
endmodule

// File: rtl/rs_row_sequencer.sv
// Module: rolling shutter row sequencer, the top level.
// What it does: a frame start loads the readout pointer and restarts the integration and
// line counters. Row clocks advance both pointers and both counters. An integration match
// loads the reset pointer and pulses the reset sync. A line-count match pulses last-line.
// Assumes: configuration is stable during a frame, pointer values are below NUM_ROWS,
// and row_clk_i is a single-cycle strobe.
module rs_row_sequencer
    import rs_seq_pkg::*;
#(
    parameter int ROW_W    = 10,
    parameter int NUM_ROWS = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic             row_clk_i,
    input  logic [ROW_W-1:0] rd_ptr_cfg_i,
    input  logic [ROW_W-1:0] rst_ptr_cfg_i,
    input  logic [11:0]      nlines_cfg_i,
    input  logic [11:0]      tint_cfg_i,
    output logic             rd_sync_o,
    output logic             rst_sync_o,
    output logic [ROW_W-1:0] rd_row_o,
    output logic [ROW_W-1:0] rst_row_o,
    output logic             last_line_o
);
    logic integ_fire;
    logic line_fire;
    logic rd_sync_q;
    logic rst_sync_q;
    logic last_q;

    // Readout pointer, loaded by the frame start.
    rs_row_ptr #(.ROW_W(ROW_W), .NUM_ROWS(NUM_ROWS)) u_rd_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (frame_start_i),
        .load_val_i (rd_ptr_cfg_i),
        .adv_i      (row_clk_i),
        .row_o      (rd_row_o)
    );

    // Reset pointer, loaded by the integration match.
    rs_row_ptr #(.ROW_W(ROW_W), .NUM_ROWS(NUM_ROWS)) u_rst_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (integ_fire),
        .load_val_i (rst_ptr_cfg_i),
        .adv_i      (row_clk_i),
        .row_o      (rst_row_o)
    );

    // Integration line counter.
    rs_match_counter u_integ_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (frame_start_i),
        .step_i   (row_clk_i),
        .target_i (cfg_t'(tint_cfg_i)),
        .fire_o   (integ_fire)
    );

    // Frame line counter.
    rs_match_counter u_line_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (frame_start_i),
        .step_i   (row_clk_i),
        .target_i (cfg_t'(nlines_cfg_i)),
        .fire_o   (line_fire)
    );

    // Purpose: register the three pulses so each one lines up with its pointer load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sync_q  <= 1'b0;
            rst_sync_q <= 1'b0;
            last_q     <= 1'b0;
        end else begin
            rd_sync_q  <= frame_start_i;
            rst_sync_q <= integ_fire;
            last_q     <= line_fire;
        end
    end

    assign rd_sync_o   = rd_sync_q;
    assign rst_sync_o  = rst_sync_q;
    assign last_line_o = last_q;
endmodule

// File: rtl/rs_row_sequencer_chk.sv
// Module: property checker for the row sequencer, attached by bind.
// Assumes: frame_start_i is a single-cycle pulse and configuration is stable within a frame.
module rs_row_sequencer_chk #(
    parameter int ROW_W    = 10,
    parameter int NUM_ROWS = 1024
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start_i,
    input logic             row_clk_i,
    input logic [ROW_W-1:0] rd_ptr_cfg_i,
    input logic [ROW_W-1:0] rst_ptr_cfg_i,
    input logic             rd_sync_o,
    input logic             rst_sync_o,
    input logic [ROW_W-1:0] rd_row_o,
    input logic [ROW_W-1:0] rst_row_o,
    input logic             last_line_o
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

    function automatic logic [ROW_W-1:0] step_row(input logic [ROW_W-1:0] r);
        return (r == LAST_ROW) ? '0 : r + 1'b1;
    endfunction

    p_rdsync_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> (rd_sync_o && rd_row_o == $past(rd_ptr_cfg_i)));

    p_rdsync_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sync_o && !frame_start_i) |=> !rd_sync_o);

    p_rd_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_clk_i && !frame_start_i) |=> (rd_row_o == step_row($past(rd_row_o))));

    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!row_clk_i && !frame_start_i) |=> $stable(rd_row_o));

    p_row_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_row_o <= LAST_ROW) && (rst_row_o <= LAST_ROW));

    p_rstsync_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_sync_o) |-> (rst_row_o == $past(rst_ptr_cfg_i)));

    p_rstsync_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_sync_o |=> !rst_sync_o);

    p_last_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last_line_o |=> !last_line_o);
endmodule

bind rs_row_sequencer rs_row_sequencer_chk #(.ROW_W(ROW_W), .NUM_ROWS(NUM_ROWS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start_i),
    .row_clk_i     (row_clk_i),
    .rd_ptr_cfg_i  (rd_ptr_cfg_i),
    .rst_ptr_cfg_i (rst_ptr_cfg_i),
    .rd_sync_o     (rd_sync_o),
    .rst_sync_o    (rst_sync_o),
    .rd_row_o      (rd_row_o),
    .rst_row_o     (rst_row_o),
    .last_line_o   (last_line_o)
);

// File: tb/rs_row_sequencer_test.sv
module rs_row_sequencer_test;
    localparam int ROW_W = 6;
    localparam int N     = 40;
    localparam int NV    = 6;
    // Each row: integration, line count, readout start, reset start, idle gap between row clocks
    localparam int VT [NV][5] = '{
        '{3, 10, 5, 20, 1},
        '{0, 7, 39, 0, 2},
        '{12, 12, 30, 38, 1},
        '{1, 45, 0, 17, 1},
        '{20, 33, 38, 2, 3},
        '{0, 0, 10, 11, 1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic row_clk = 1'b0;
    logic [ROW_W-1:0] rd_cfg = '0;
    logic [ROW_W-1:0] rst_cfg = '0;
    logic [11:0] nl_cfg = '0;
    logic [11:0] ti_cfg = '0;
    logic rd_sync, rst_sync, last_line;
    logic [ROW_W-1:0] rd_row, rst_row;

    int checks = 0;
    int fails = 0;
    int rows = 0;
    int rd_cnt = 0, rs_cnt = 0, ll_cnt = 0;
    int rs_at = -1, ll_at = -1, rs_row_seen = -1;

    always #2 clk = ~clk;

    rs_row_sequencer #(.ROW_W(ROW_W), .NUM_ROWS(N)) uut (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start), .row_clk_i(row_clk),
        .rd_ptr_cfg_i(rd_cfg), .rst_ptr_cfg_i(rst_cfg), .nlines_cfg_i(nl_cfg),
        .tint_cfg_i(ti_cfg), .rd_sync_o(rd_sync), .rst_sync_o(rst_sync),
        .rd_row_o(rd_row), .rst_row_o(rst_row), .last_line_o(last_line)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr();
        rows = 0; rd_cnt = 0; rs_cnt = 0; ll_cnt = 0;
        rs_at = -1; ll_at = -1; rs_row_seen = -1;
    endtask

    // One clock: drive inputs, wait for the edge, sample just after it
    task automatic tick(input bit rc, input bit fs);
        row_clk = rc; frame_start = fs;
        @(posedge clk); #1;
        row_clk = 1'b0; frame_start = 1'b0;
        if (fs) rows = 0;
        else if (rc) rows++;
        if (rd_sync) rd_cnt++;
        if (rst_sync) begin rs_cnt++; rs_at = rows; rs_row_seen = int'(rst_row); end
        if (last_line) begin ll_cnt++; ll_at = rows; end
    endtask

    task automatic row(input int gap);
        repeat (gap) tick(1'b0, 1'b0);
        tick(1'b1, 1'b0);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        clr();
        // R1: reset state
        chk("R1 rd_sync", int'(rd_sync), 0);
        chk("R1 rst_sync", int'(rst_sync), 0);
        chk("R1 last_line", int'(last_line), 0);
        chk("R1 rd_row", int'(rd_row), 0);
        chk("R1 rst_row", int'(rst_row), 0);
        // R1/R3: row clocks before any frame start move pointers, no pulses
        row(1); row(1); tick(1'b0, 1'b0);
        chk("R3 rd_row pre-frame", int'(rd_row), 2);
        chk("R3 rst_row pre-frame", int'(rst_row), 2);
        chk("R1 no pulses pre-frame", rd_cnt + rs_cnt + ll_cnt, 0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            ti_cfg = 12'(VT[v][0]); nl_cfg = 12'(VT[v][1]);
            rd_cfg = ROW_W'(VT[v][2]); rst_cfg = ROW_W'(VT[v][3]);
            clr();
            tick(1'b0, 1'b1);
            chk("R2 rd_sync after start", int'(rd_sync), 1);
            chk("R2 rd_row loaded", int'(rd_row), VT[v][2]);
            for (int k = 1; k <= VT[v][1] + 2; k++) begin
                row(VT[v][4]);
                chk("R3/R4 rd_row advance", int'(rd_row), (VT[v][2] + k) % N);
            end
            tick(1'b0, 1'b0); tick(1'b0, 1'b0);
            chk("R2 one readout sync", rd_cnt, 1);
            chk("R9 reset sync count", rs_cnt, 1);
            chk("R5 reset sync row clocks", rs_at, VT[v][0]);
            chk("R5 reset row loaded", rs_row_seen, VT[v][3]);
            chk("R6 last-line count", ll_cnt, 1);
            chk("R6 last-line row clocks", ll_at, VT[v][1]);
            chk("R10 integration lines", ll_at - rs_at, VT[v][1] - VT[v][0]);
            chk("R4 reset row final", int'(rst_row),
                (VT[v][3] + VT[v][1] + 2 - VT[v][0]) % N);
        end

        // R7: loads win over coincident row clocks
        ti_cfg = 12'd1; nl_cfg = 12'd4; rd_cfg = 6'd7; rst_cfg = 6'd33;
        clr();
        tick(1'b1, 1'b1);
        chk("R7 rd_row held on load", int'(rd_row), 7);
        chk("R7 rd_sync", int'(rd_sync), 1);
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        chk("R7 rst_sync on coincident clock", int'(rst_sync), 1);
        chk("R7 rst_row held on load", int'(rst_row), 33);
        chk("R7 rd_row advanced", int'(rd_row), 9);
        row(1);
        chk("R7 rst_row advances after", int'(rst_row), 34);

        // R8: mid-frame restart discards counted rows
        ti_cfg = 12'd5; nl_cfg = 12'd8; rd_cfg = 6'd2; rst_cfg = 6'd9;
        clr();
        tick(1'b0, 1'b1);
        row(1); row(1); row(1); tick(1'b0, 1'b0);
        chk("R8 no reset sync before restart", rs_cnt, 0);
        clr();
        tick(1'b0, 1'b1);
        chk("R8 restart reloads rd_row", int'(rd_row), 2);
        for (int k = 0; k < 10; k++) row(1);
        tick(1'b0, 1'b0);
        chk("R8 reset sync after restart", rs_at, 5);
        chk("R8 last-line after restart", ll_at, 8);
        chk("R9 single pulses after restart", rs_cnt + ll_cnt, 2);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule